// File: doc/BRIEF.md
# Fast A20 Gate Controller

This block drives the A20 address-gate pin straight from host write traffic on the first host-interface channel, so that no firmware interrupt routine has to copy the gate bit. It watches each host write to that channel. A write is either a command or a data byte. When a gate-control command of value 0xD1 is followed by a data byte, bit 1 of that data byte becomes the new gate level on the next clock edge.

A fast-path enable input chooses where the pin level comes from. When the enable is set, the pin shows the hardware-tracked level. When it is clear, the pin follows a value that firmware supplies. The hardware level resets to logic 1. Any other command cancels a pending gate command. A data byte that has no pending gate command in front of it does not move the gate.

Top module: `a20_fast_gate`

## Requirements
- R1: A host write is a one-cycle pulse on `host_wr`. `host_cmd`=1 marks the byte on `host_wdata` as a command and `host_cmd`=0 marks it as data. Writes on consecutive cycles are each taken as a separate write.
- R2: With `fast_en`=1, the command 0xD1 followed by a data write sets the gate level to bit 1 of that data byte. `gate_a20` shows the new level from the clock edge that captures the data write.
- R3: With `fast_en`=0, `gate_a20` equals `fw_gate` in the same cycle.
- R4: Synchronous reset (`rst`=1) sets the hardware gate level to 1 and clears any pending gate command.
- R5: A data write with no pending 0xD1 leaves the gate level unchanged.
- R6: A command write of any value other than 0xD1 cancels a pending 0xD1, so the data write that follows is ignored.
- R7: One data write uses up a pending 0xD1. A second data write with no new 0xD1 leaves the level unchanged.
- R8: While `fast_en`=0, host writes neither change the hardware level nor leave a command pending, and any pending command is cleared.
- R9: Repeating 0xD1 keeps the command pending. Between qualifying writes the level holds through idle cycles.
- R10: With `fast_en`=1, changes on `fw_gate` have no effect on `gate_a20`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Channel-1 host write strobe, one cycle per write |
| host_cmd | input | 1 | 1 = command byte, 0 = data byte |
| host_wdata | input | 8 | Byte written by the host |
| fast_en | input | 1 | 1 selects the hardware gate path |
| fw_gate | input | 1 | Gate level supplied by firmware |
| gate_a20 | output | 1 | A20 gate pin level |

## Verification
The assertions check the following on every cycle:
- the gate level taken from a qualifying data write;
- the level holding after unqualified data writes, idle cycles and disabled cycles;
- a foreign command cancelling the pending state;
- the level after reset;
- the end-to-end command-then-data sequence at the ports.

Some behaviour only the bench scenarios can show:
- choosing between the firmware and hardware sources, including firmware toggling while the hardware path is active;
- a pending command being discarded across a disable;
- back-to-back writes;
- a reset in the middle of a sequence.

A behavioural reference model checks these on every clock.

// File: rtl/a20_gate_pkg.sv
package a20_gate_pkg;

    localparam int unsigned HOST_DW = 8;

    // Classified host write event.
    typedef enum logic [1:0] {
        EV_NONE      = 2'd0,
        EV_CMD_GATE  = 2'd1,
        EV_CMD_OTHER = 2'd2,
        EV_DATA      = 2'd3
    } host_ev_e;

    typedef struct packed {
        host_ev_e kind;
        logic     gate_bit;
    } host_evt_t;

    function automatic host_ev_e classify_write(
        input logic stb,
        input logic is_cmd,
        input logic code_match
    );
        host_ev_e k;
        if (!stb)
            k = EV_NONE;
        else if (!is_cmd)
            k = EV_DATA;
        else if (code_match)
            k = EV_CMD_GATE;
        else
            k = EV_CMD_OTHER;
        return k;
    endfunction

endpackage

// File: rtl/a20_host_decode.sv
module a20_host_decode
    import a20_gate_pkg::*;
#(
    parameter int unsigned        DATA_W   = HOST_DW,
    parameter logic [DATA_W-1:0]  CMD_CODE = 8'hD1,
    parameter int unsigned        GATE_BIT = 1
) (
    input  logic              wr_stb,
    input  logic              wr_is_cmd,
    input  logic [DATA_W-1:0] wr_byte,
    output host_evt_t         evt
);
    logic code_match;

    assign code_match = (wr_byte == CMD_CODE);

    always_comb begin
        evt.kind     = classify_write(wr_stb, wr_is_cmd, code_match);
        evt.gate_bit = wr_byte[GATE_BIT];
    end

endmodule

// File: rtl/a20_seq_track.sv
module a20_seq_track
    import a20_gate_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  host_evt_t evt,
    output logic      level_q,
    output logic      armed_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= RESET_LEVEL;
            armed_q <= 1'b0;
        end else if (!enable) begin
            armed_q <= 1'b0;
        end else begin
            unique case (evt.kind)
                EV_CMD_GATE:  armed_q <= 1'b1;
                EV_CMD_OTHER: armed_q <= 1'b0;
                EV_DATA: begin
                    if (armed_q)
                        level_q <= evt.gate_bit;
                    armed_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R4: reset forces the level high and drops the pending command
    a_r4_reset_level: assert property (@(posedge clk)
        rst |=> (level_q == RESET_LEVEL) && !armed_q);

    // R2: a data byte arriving while armed sets the level
    a_r2_take_bit: assert property (@(posedge clk) disable iff (rst)
        (enable && armed_q && evt.kind == EV_DATA) |=> level_q == $past(evt.gate_bit));

    // R5: a data byte arriving while not armed is ignored
    a_r5_unarmed_hold: assert property (@(posedge clk) disable iff (rst)
        (evt.kind == EV_DATA && !armed_q) |=> $stable(level_q));

    // R6: a foreign command clears the pending state
    a_r6_cancel: assert property (@(posedge clk) disable iff (rst)
        (enable && evt.kind == EV_CMD_OTHER) |=> !armed_q);

    // R8: while disabled the level is frozen and nothing stays armed
    a_r8_disabled: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(level_q) && !armed_q);

    // R9: an idle cycle keeps the level
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (evt.kind == EV_NONE) |=> $stable(level_q));

endmodule

// File: rtl/a20_out_sel.sv
module a20_out_sel (
    input  logic hw_path,
    input  logic hw_level,
    input  logic fw_level,
    output logic pin_level
);
    always_comb begin
        pin_level = hw_path ? hw_level : fw_level;
    end
endmodule

// File: rtl/a20_fast_gate.sv
module a20_fast_gate
    import a20_gate_pkg::*;
#(
    parameter int unsigned       DATA_W      = HOST_DW,
    parameter logic [DATA_W-1:0] CMD_CODE    = 8'hD1,
    parameter int unsigned       GATE_BIT    = 1,
    parameter logic              RESET_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_cmd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              fast_en,
    input  logic              fw_gate,
    output logic              gate_a20
);
    host_evt_t evt;
    logic      hw_level;
    logic      hw_armed;

    a20_host_decode #(
        .DATA_W  (DATA_W),
        .CMD_CODE(CMD_CODE),
        .GATE_BIT(GATE_BIT)
    ) u_decode (
        .wr_stb   (host_wr),
        .wr_is_cmd(host_cmd),
        .wr_byte  (host_wdata),
        .evt      (evt)
    );

    a20_seq_track #(
        .RESET_LEVEL(RESET_LEVEL)
    ) u_track (
        .clk    (clk),
        .rst    (rst),
        .enable (fast_en),
        .evt    (evt),
        .level_q(hw_level),
        .armed_q(hw_armed)
    );

    a20_out_sel u_sel (
        .hw_path  (fast_en),
        .hw_level (hw_level),
        .fw_level (fw_gate),
        .pin_level(gate_a20)
    );

    // R2: port-level command-then-data sequence reaches the pin
    a_r2_port_sequence: assert property (@(posedge clk) disable iff (rst)
        (fast_en && host_wr && host_cmd && host_wdata == CMD_CODE)
        ##1 (fast_en && host_wr && !host_cmd)
        |=> (!fast_en || gate_a20 == $past(host_wdata[GATE_BIT])));

endmodule

// File: tb/test_a20_fast_gate.sv
module test_a20_fast_gate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_cmd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       fast_en = 1'b1;
    logic       fw_gate = 1'b0;
    logic       gate_a20;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R4";
    bit    done = 1'b0;

    // behavioural reference state
    int ref_level = 1;
    int ref_armed = 0;

    always #5 clk = ~clk;

    a20_fast_gate i_a20_fast_gate (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_cmd  (host_cmd),
        .host_wdata(host_wdata),
        .fast_en   (fast_en),
        .fw_gate   (fw_gate),
        .gate_a20  (gate_a20)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        if (rst) begin
            ref_level = 1;
            ref_armed = 0;
        end else if (!fast_en) begin
            ref_armed = 0;
        end else if (host_wr) begin
            if (host_cmd) ref_armed = (host_wdata == 8'hD1) ? 1 : 0;
            else begin
                if (ref_armed == 1) ref_level = host_wdata[1];
                ref_armed = 0;
            end
        end
    end

    // per-clock comparison away from the edges
    always @(posedge clk) begin
        #3;
        if (!rst && !done)
            chk(gate_a20, fast_en ? ref_level[0] : fw_gate, {cur_req, " model"});
    end

    // called at a negedge; returns at the next negedge
    task automatic hwr(input logic cmd, input logic [7:0] b);
        host_wr = 1'b1; host_cmd = cmd; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0; host_cmd = 1'b0; host_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(gate_a20, 1'b1, "R4 reset level");
        rst = 1'b0;
        idle(2);
        chk(gate_a20, 1'b1, "R4 after reset");

        cur_req = "R2";
        hwr(1, 8'hD1); hwr(0, 8'h00);
        chk(gate_a20, 1'b0, "R2 bit1=0");
        hwr(1, 8'hD1); hwr(0, 8'h02);
        chk(gate_a20, 1'b1, "R2 bit1=1");
        hwr(1, 8'hD1); hwr(0, 8'hFD);
        chk(gate_a20, 1'b0, "R2 0xFD");

        cur_req = "R5";
        hwr(0, 8'h02);
        chk(gate_a20, 1'b0, "R5 unarmed data");

        cur_req = "R6";
        hwr(1, 8'hD1); hwr(1, 8'hAA); hwr(0, 8'h02);
        chk(gate_a20, 1'b0, "R6 cancelled");

        cur_req = "R7";
        hwr(1, 8'hD1); hwr(0, 8'h02);
        chk(gate_a20, 1'b1, "R7 first data");
        hwr(0, 8'h00);
        chk(gate_a20, 1'b1, "R7 second data ignored");

        cur_req = "R9";
        hwr(1, 8'hD1); hwr(1, 8'hD1); hwr(0, 8'h00);
        chk(gate_a20, 1'b0, "R9 repeated D1");
        idle(5);
        chk(gate_a20, 1'b0, "R9 idle hold");

        cur_req = "R1";
        hwr(1, 8'hD1); idle(3); hwr(0, 8'h06);
        chk(gate_a20, 1'b1, "R1 spaced writes");

        cur_req = "R3";
        fast_en = 1'b0; fw_gate = 1'b0; #1;
        chk(gate_a20, 1'b0, "R3 fw 0");
        fw_gate = 1'b1; #1;
        chk(gate_a20, 1'b1, "R3 fw 1");
        fw_gate = 1'b0;
        @(negedge clk);

        cur_req = "R8";
        hwr(1, 8'hD1); hwr(0, 8'h00);
        fast_en = 1'b1; #1;
        chk(gate_a20, 1'b1, "R8 disabled writes ignored");
        @(negedge clk);
        hwr(1, 8'hD1);
        fast_en = 1'b0; @(negedge clk); fast_en = 1'b1;
        hwr(0, 8'h00);
        chk(gate_a20, 1'b1, "R8 pending cleared by disable");

        cur_req = "R10";
        fw_gate = 1'b0; #1;
        chk(gate_a20, 1'b1, "R10 fw low ignored");
        @(negedge clk);
        fw_gate = 1'b1; hwr(1, 8'hD1); hwr(0, 8'h00);
        chk(gate_a20, 1'b0, "R10 fw high ignored");

        cur_req = "R4";
        hwr(1, 8'hD1);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk(gate_a20, 1'b1, "R4 mid reset");
        hwr(0, 8'h00);
        chk(gate_a20, 1'b1, "R4 pending dropped by reset");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule